// File: doc/BRIEF.md
# Deferred-Fault Poison Tracker

This block keeps a small architectural register file for an in-order wide-issue datapath. Next to each register value it keeps a one-bit poison flag that marks a deferred fault. A speculative load whose memory access faults does not trap. It writes its destination and marks that register as poisoned. Arithmetic operations carry the marks forward: the mark on a destination is the OR of the marks on its sources. The fault becomes visible only at an explicit check operation or at a non-speculative consumer. A check operation turns a mark into a redirect to a fix-up address supplied with the operation. A store or a branch that reads a marked register raises a trap and reports that register's index.

One decoded operation per cycle enters on the `in_*` ports. The memory system's returned data and fault flag arrive in the same cycle as a load operation. The effect appears one cycle later on exactly one of three registered outputs: a write-back, a redirect or a trap. Every output field is zero when its valid flag is low. Register values live in a memory with no reset. A per-register "written since reset" flag makes every register read as zero until it is first written.

Top module: `dfu_top`

## Requirements
- R1: A speculative load (op code 3) never raises a trap, whatever the memory fault input is.
- R2: A speculative load that sees `mem_fault`=1 writes its destination with data 0 and poison 1.
- R3: A speculative load that sees `mem_fault`=0 writes `mem_data` to its destination with poison 0.
- R4: An ALU operation (op code 1) writes `src_a + src_b` modulo 2^DW to its destination, with poison equal to the OR of the two source poison bits, and never traps.
- R5: A check operation (op code 4) on a poisoned `src_a` pulses `redir_valid` with `redir_tgt` = `in_fix_tgt`. On a clean register it produces no output at all.
- R6: A non-speculative load (op code 2) without a fault writes `mem_data` and clears the destination's poison bit. With a fault it traps with `trap_idx` = destination and writes nothing.
- R7: A store (op code 5) traps when `src_a` is poisoned (`trap_idx`=`src_a`), else when `src_b` is poisoned (`trap_idx`=`src_b`). A branch (op code 6) traps when `src_a` is poisoned. A clean store or branch produces no output.
- R8: A write aimed at register 0 produces no write-back pulse. Register 0 always reads as value 0 with poison 0.
- R9: Outputs appear on the clock edge after the operation is presented, each for one cycle, and at most one of `wb_valid`, `redir_valid`, `trap_valid` is high at a time. An invalid slot, op code 0 or op code 7 produces no output.
- R10: After reset all outputs are low and every register reads as value 0 with poison 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is present this cycle |
| in_op | input | 3 | Operation code (see R1 to R9) |
| in_src_a | input | IW | First source register index |
| in_src_b | input | IW | Second source register index |
| in_dst | input | IW | Destination register index |
| in_fix_tgt | input | AW | Fix-up address for a check operation |
| mem_data | input | DW | Data returned for a load |
| mem_fault | input | 1 | Memory reports a fault for this load |
| wb_valid | output | 1 | Register write-back pulse |
| wb_idx | output | IW | Register written |
| wb_data | output | DW | Value written |
| wb_poison | output | 1 | Poison bit written |
| redir_valid | output | 1 | Redirect request pulse |
| redir_tgt | output | AW | Redirect target |
| trap_valid | output | 1 | Trap pulse |
| trap_idx | output | IW | Register that caused the trap |

## Verification
The assertions take for granted that `mem_fault` and `mem_data` are meaningful only with a load operation, and that `in_valid` stays low while `rst` is high, so the first post-reset cycle carries no stale operation. The stimulus holds `in_valid` low during reset. It then sweeps every op code against every pair of source registers, with the destination and fault pattern derived arithmetically from the loop indices, so poison is created, propagated, checked and cleared in many orders. Faults are fed to every operation kind, including the ones that must ignore them.

// File: rtl/dfu_pkg.sv
package dfu_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ALU = 3'd1,
    OP_LD  = 3'd2,
    OP_LDS = 3'd3,
    OP_CHK = 3'd4,
    OP_ST  = 3'd5,
    OP_BR  = 3'd6,
    OP_RSV = 3'd7
  } op_e;
endpackage

// File: rtl/dfu_value_rf.sv
module dfu_value_rf #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr_a,
  input  logic [IW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  // Plain memory without reset so it can map to distributed RAM.
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/dfu_tag_rf.sv
module dfu_tag_rf #(
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic          wpoison,
  input  logic [IW-1:0] raddr_a,
  input  logic [IW-1:0] raddr_b,
  output logic          poison_a,
  output logic          poison_b,
  output logic          live_a,
  output logic          live_b
);
  logic [NREG-1:0] poison_q;
  logic [NREG-1:0] live_q;

  for (genvar g = 0; g < NREG; g++) begin : g_tag
    if (g == 0) begin : g_zero
      // Register 0 is hard-wired: never live, never poisoned.
      assign poison_q[g] = 1'b0;
      assign live_q[g]   = 1'b0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          poison_q[g] <= 1'b0;
          live_q[g]   <= 1'b0;
        end else if (we && (waddr == IW'(g))) begin
          poison_q[g] <= wpoison;
          live_q[g]   <= 1'b1;
        end
      end
    end
  end

  assign poison_a = poison_q[raddr_a];
  assign poison_b = poison_q[raddr_b];
  assign live_a   = live_q[raddr_a];
  assign live_b   = live_q[raddr_b];
endmodule

// File: rtl/dfu_resolve.sv
module dfu_resolve
  import dfu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int AW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          valid,
  input  op_e           op,
  input  logic [IW-1:0] src_a,
  input  logic [IW-1:0] src_b,
  input  logic [IW-1:0] dst,
  input  logic [AW-1:0] fix_tgt,
  input  logic [DW-1:0] val_a,
  input  logic [DW-1:0] val_b,
  input  logic          pois_a,
  input  logic          pois_b,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_fault,
  output logic          wb_en,
  output logic [DW-1:0] wb_val,
  output logic          wb_pois,
  output logic          rd_en,
  output logic [AW-1:0] rd_tgt,
  output logic          tp_en,
  output logic [IW-1:0] tp_idx
);
  logic dst_live;
  assign dst_live = (dst != '0);

  always_comb begin
    wb_en   = 1'b0;
    wb_val  = '0;
    wb_pois = 1'b0;
    rd_en   = 1'b0;
    rd_tgt  = '0;
    tp_en   = 1'b0;
    tp_idx  = '0;
    if (valid) begin
      case (op)
        OP_ALU: begin
          wb_en   = dst_live;
          wb_val  = val_a + val_b;
          wb_pois = pois_a | pois_b;
        end
        OP_LDS: begin
          // Deferred fault: never traps, marks the destination instead.
          wb_en   = dst_live;
          wb_val  = ld_fault ? '0 : ld_data;
          wb_pois = ld_fault;
        end
        OP_LD: begin
          if (ld_fault) begin
            tp_en  = 1'b1;
            tp_idx = dst;
          end else begin
            wb_en  = dst_live;
            wb_val = ld_data;
          end
        end
        OP_CHK: begin
          if (pois_a) begin
            rd_en  = 1'b1;
            rd_tgt = fix_tgt;
          end
        end
        OP_ST: begin
          if (pois_a) begin
            tp_en  = 1'b1;
            tp_idx = src_a;
          end else if (pois_b) begin
            tp_en  = 1'b1;
            tp_idx = src_b;
          end
        end
        OP_BR: begin
          if (pois_a) begin
            tp_en  = 1'b1;
            tp_idx = src_a;
          end
        end
        default: ;
      endcase
    end
    if (!wb_en) begin
      wb_val  = '0;
      wb_pois = 1'b0;
    end
  end
endmodule

// File: rtl/dfu_top.sv
module dfu_top
  import dfu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int AW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [IW-1:0] in_src_a,
  input  logic [IW-1:0] in_src_b,
  input  logic [IW-1:0] in_dst,
  input  logic [AW-1:0] in_fix_tgt,
  input  logic [DW-1:0] mem_data,
  input  logic          mem_fault,
  output logic          wb_valid,
  output logic [IW-1:0] wb_idx,
  output logic [DW-1:0] wb_data,
  output logic          wb_poison,
  output logic          redir_valid,
  output logic [AW-1:0] redir_tgt,
  output logic          trap_valid,
  output logic [IW-1:0] trap_idx
);
  logic [DW-1:0] raw_a, raw_b, val_a, val_b;
  logic          pois_a, pois_b, live_a, live_b;
  logic          n_wb_en, n_wb_pois, n_rd_en, n_tp_en;
  logic [DW-1:0] n_wb_val;
  logic [AW-1:0] n_rd_tgt;
  logic [IW-1:0] n_tp_idx;

  dfu_value_rf #(.NREG(NREG), .DW(DW)) u_vals (
    .clk     (clk),
    .we      (n_wb_en),
    .waddr   (in_dst),
    .wdata   (n_wb_val),
    .raddr_a (in_src_a),
    .raddr_b (in_src_b),
    .rdata_a (raw_a),
    .rdata_b (raw_b)
  );

  dfu_tag_rf #(.NREG(NREG)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .we       (n_wb_en),
    .waddr    (in_dst),
    .wpoison  (n_wb_pois),
    .raddr_a  (in_src_a),
    .raddr_b  (in_src_b),
    .poison_a (pois_a),
    .poison_b (pois_b),
    .live_a   (live_a),
    .live_b   (live_b)
  );

  // Registers never written since reset read as zero.
  assign val_a = live_a ? raw_a : '0;
  assign val_b = live_b ? raw_b : '0;

  dfu_resolve #(.NREG(NREG), .DW(DW), .AW(AW)) u_res (
    .valid    (in_valid),
    .op       (op_e'(in_op)),
    .src_a    (in_src_a),
    .src_b    (in_src_b),
    .dst      (in_dst),
    .fix_tgt  (in_fix_tgt),
    .val_a    (val_a),
    .val_b    (val_b),
    .pois_a   (pois_a),
    .pois_b   (pois_b),
    .ld_data  (mem_data),
    .ld_fault (mem_fault),
    .wb_en    (n_wb_en),
    .wb_val   (n_wb_val),
    .wb_pois  (n_wb_pois),
    .rd_en    (n_rd_en),
    .rd_tgt   (n_rd_tgt),
    .tp_en    (n_tp_en),
    .tp_idx   (n_tp_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid    <= 1'b0;
      wb_idx      <= '0;
      wb_data     <= '0;
      wb_poison   <= 1'b0;
      redir_valid <= 1'b0;
      redir_tgt   <= '0;
      trap_valid  <= 1'b0;
      trap_idx    <= '0;
    end else begin
      wb_valid    <= n_wb_en;
      wb_idx      <= n_wb_en ? in_dst : '0;
      wb_data     <= n_wb_val;
      wb_poison   <= n_wb_pois;
      redir_valid <= n_rd_en;
      redir_tgt   <= n_rd_tgt;
      trap_valid  <= n_tp_en;
      trap_idx    <= n_tp_idx;
    end
  end
endmodule

// File: rtl/dfu_checker.sv
module dfu_checker #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int AW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    in_op,
  input logic [IW-1:0] in_src_a,
  input logic [IW-1:0] in_dst,
  input logic [AW-1:0] in_fix_tgt,
  input logic          mem_fault,
  input logic          wb_valid,
  input logic [IW-1:0] wb_idx,
  input logic [DW-1:0] wb_data,
  input logic          wb_poison,
  input logic          redir_valid,
  input logic [AW-1:0] redir_tgt,
  input logic          trap_valid,
  input logic [IW-1:0] trap_idx
);
  AST_LDS_NEVER_TRAPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd3) |=> !trap_valid); // R1

  AST_LDS_FAULT_MARKS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd3 && mem_fault && in_dst != '0)
    |=> (wb_valid && wb_poison && wb_data == '0)); // R2

  AST_ALU_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd1) |=> !trap_valid && !redir_valid); // R4

  AST_CHK_TARGET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd4) |=> (!wb_valid && !trap_valid
      && (!redir_valid || redir_tgt == $past(in_fix_tgt)))); // R5

  AST_REDIR_FROM_CHK: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> ($past(in_valid) && $past(in_op) == 3'd4)); // R5

  AST_LD_FAULT_TRAPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd2 && mem_fault)
    |=> (trap_valid && !wb_valid && trap_idx == $past(in_dst))); // R6

  AST_BR_TRAP_IDX: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd6) |=> (!trap_valid || trap_idx == $past(in_src_a))); // R7

  AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wb_idx != '0); // R8

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wb_valid, redir_valid, trap_valid})); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(wb_valid || redir_valid || trap_valid)); // R9
endmodule

bind dfu_top dfu_checker #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_op       (in_op),
  .in_src_a    (in_src_a),
  .in_dst      (in_dst),
  .in_fix_tgt  (in_fix_tgt),
  .mem_fault   (mem_fault),
  .wb_valid    (wb_valid),
  .wb_idx      (wb_idx),
  .wb_data     (wb_data),
  .wb_poison   (wb_poison),
  .redir_valid (redir_valid),
  .redir_tgt   (redir_tgt),
  .trap_valid  (trap_valid),
  .trap_idx    (trap_idx)
);

// File: tb/sim_dfu_top.sv
`timescale 1ns/1ps
module sim_dfu_top;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int AW   = 16;
  localparam int IW   = $clog2(NREG);
  localparam int VW   = 1 + IW + DW + 1 + 1 + AW + 1 + IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_op = '0;
  logic [IW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [AW-1:0] in_fix_tgt = '0;
  logic [DW-1:0] mem_data = '0;
  logic          mem_fault = 1'b0;
  logic          wb_valid, wb_poison, redir_valid, trap_valid;
  logic [IW-1:0] wb_idx, trap_idx;
  logic [DW-1:0] wb_data;
  logic [AW-1:0] redir_tgt;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] mval [NREG];
  logic          mpois [NREG];

  always #2 clk = ~clk;

  dfu_top #(.NREG(NREG), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .in_fix_tgt(in_fix_tgt), .mem_data(mem_data), .mem_fault(mem_fault),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .wb_poison(wb_poison), .redir_valid(redir_valid), .redir_tgt(redir_tgt),
    .trap_valid(trap_valid), .trap_idx(trap_idx)
  );

  function automatic logic [VW-1:0] outs();
    return {wb_valid, wb_idx, wb_data, wb_poison,
            redir_valid, redir_tgt, trap_valid, trap_idx};
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic v, input logic [2:0] op, input int a, input int b,
                        input int d, input logic f, input logic [DW-1:0] md,
                        input logic [AW-1:0] tgt, input string tag_in);
    logic [DW-1:0] va, vb;
    logic pa, pb;
    logic e_wb, e_wp, e_rd, e_tp;
    logic [DW-1:0] e_wd;
    logic [IW-1:0] e_ti;
    logic [AW-1:0] e_rt;
    string tag;
    in_valid = v; in_op = op; in_src_a = IW'(a); in_src_b = IW'(b);
    in_dst = IW'(d); mem_fault = f; mem_data = md; in_fix_tgt = tgt;
    va = (a == 0) ? '0 : mval[a];  pa = (a == 0) ? 1'b0 : mpois[a];
    vb = (b == 0) ? '0 : mval[b];  pb = (b == 0) ? 1'b0 : mpois[b];
    e_wb = 0; e_wp = 0; e_rd = 0; e_tp = 0; e_wd = '0; e_ti = '0; e_rt = '0;
    tag = "R9";
    if (v) begin
      case (op)
        3'd1: begin tag = "R4"; e_wb = 1; e_wd = va + vb; e_wp = pa | pb; end
        3'd3: begin tag = f ? "R2" : "R3"; e_wb = 1; e_wd = f ? '0 : md; e_wp = f; end
        3'd2: begin tag = "R6";
          if (f) begin e_tp = 1; e_ti = IW'(d); end else begin e_wb = 1; e_wd = md; end
        end
        3'd4: begin tag = "R5"; if (pa) begin e_rd = 1; e_rt = tgt; end end
        3'd5: begin tag = "R7";
          if (pa) begin e_tp = 1; e_ti = IW'(a); end
          else if (pb) begin e_tp = 1; e_ti = IW'(b); end
        end
        3'd6: begin tag = "R7"; if (pa) begin e_tp = 1; e_ti = IW'(a); end end
        default: tag = "R9";
      endcase
    end
    if (e_wb && d == 0) begin
      tag = "R8"; e_wb = 0; e_wd = '0; e_wp = 0;
    end
    if (tag_in != "") tag = tag_in;
    @(negedge clk);
    check(tag, outs(), {e_wb, e_wb ? IW'(d) : IW'(0), e_wd, e_wp, e_rd, e_rt, e_tp, e_ti});
    if (v && op == 3'd3) begin
      checks++;
      if (trap_valid !== 1'b0) begin
        fails++;
        $display("FAIL R1: actual trap %b expected 0", trap_valid);
      end
    end
    if (e_wb) begin mval[d] = e_wd; mpois[d] = e_wp; end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin mval[i] = '0; mpois[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10", outs(), '0);
    // Every register reads zero and clean after reset.
    for (int r = 0; r < NREG; r++)
      run_op(1, 3'd1, r, 0, r, 0, '0, '0, "R10");
    // Directed: fault deferred, carried, caught, then cleared.
    run_op(1, 3'd2, 0, 0, 1, 0, 16'h1234, '0, "");    // R6 clean load
    run_op(1, 3'd3, 0, 0, 3, 1, 16'hdead, '0, "");    // R2 deferred fault
    run_op(1, 3'd1, 3, 1, 4, 0, '0, '0, "");          // R4 poison carried
    run_op(1, 3'd4, 4, 0, 0, 0, '0, 16'h0abc, "");    // R5 redirect
    run_op(1, 3'd5, 1, 4, 0, 0, '0, '0, "");          // R7 store data poisoned
    run_op(1, 3'd6, 3, 0, 0, 0, '0, '0, "");          // R7 branch on poison
    run_op(1, 3'd2, 0, 0, 3, 0, 16'h0042, '0, "");    // R6 clears poison
    run_op(1, 3'd4, 3, 0, 0, 0, '0, 16'h0abc, "");    // R5 clean check is silent
    run_op(1, 3'd3, 0, 0, 0, 1, 16'h0001, '0, "");    // R8 write to r0 ignored
    run_op(1, 3'd4, 0, 0, 0, 0, '0, 16'h0777, "R8");  // r0 never poisoned
    run_op(1, 3'd2, 0, 0, 5, 1, 16'h5555, '0, "");    // R6 faulting load traps
    // Near-exhaustive sweep: every op code against every source pair.
    for (int p = 0; p < 3; p++)
      for (int op = 0; op < 8; op++)
        for (int a = 0; a < NREG; a++)
          for (int b = 0; b < NREG; b++)
            run_op(((a + b + op + p) % 11) != 0, 3'(op), a, b,
                   (a * 5 + b + op + p) % NREG,
                   ((a * 3 + b + op + p) % 4) == 0,
                   DW'(a * 37 + b * 11 + p * 101 + op * 7 + 5),
                   AW'(a * 300 + b * 3 + p), "");
    in_valid = 1'b0;
    @(negedge clk);
    check("R9", outs(), '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9: watchdog expired, actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule